// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block renames a group of up to `GROUP` instructions in one cycle. Each instruction has two logical source registers and, optionally, one logical destination register. For each source the block returns a physical register number, and for each destination it returns a freshly allocated one. Sources are looked up in a map table that has one entry per logical register. A source that names a logical register written by an earlier instruction in the same group takes that instruction's new physical register instead.

New physical registers come from a free pool, which is held as one bit per physical register. The reclamation logic outside this block returns registers to the pool through a single free port. If the pool cannot cover every destination in the group, the whole group stalls.

For recovery, a shift-register stack holds up to `DEPTH` shadow copies of the map. A push captures the map as it will stand after the current cycle. A restore copies a chosen shadow back into the live map in one cycle and discards that copy together with every newer one.

Top module: `rename_map`

## Requirements
- R1: After reset, logical register n maps to physical register n for every n below `LREGS`. The free pool holds physical registers `LREGS` to `PREGS-1`. Physical register 0 is never handed out.
- R2: In a group that fires, each instruction with `dst_en[i]`=1 receives the lowest-numbered free register that no earlier instruction of the group took. An instruction with `dst_en[i]`=0 shows 0 on its lane of `dst_p`.
- R3: A source with no earlier in-group writer of the same logical register reads the map table.
- R4: A source whose logical register is written by one or more earlier instructions of the same group takes the physical register of the nearest such writer.
- R5: When several instructions in a group write the same logical register, the table keeps the mapping of the last of them.
- R6: `grp_ready` is low when the pool holds fewer free registers than `dst_en` has set bits. While `grp_ready` is low, the map and the pool are not changed by the group.
- R7: `free_en` with `free_id` ≠ 0 returns that register to the pool at the next edge. `free_id` = 0 is ignored.
- R8: `ckpt_push` stores the post-cycle map as the newest shadow copy. The stack holds `DEPTH` copies, and a push onto a full stack drops the oldest.
- R9: `restore_en` with `restore_sel` = k (0 = newest) loads shadow k into the map at the next edge and removes copies 0 to k. If k is not less than the number of stored copies, the restore is ignored. `grp_ready` is low whenever `restore_en` is high.
- R10: While `restore_en` is high, `ckpt_push` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_valid | input | 1 | A rename group is presented |
| dst_en | input | GROUP | Per-instruction destination present |
| src_a | input | GROUP*LW | Logical source A per lane |
| src_b | input | GROUP*LW | Logical source B per lane |
| dst | input | GROUP*LW | Logical destination per lane |
| free_en | input | 1 | Return a register to the pool |
| free_id | input | PW | Register being returned |
| ckpt_push | input | 1 | Push a shadow copy |
| restore_en | input | 1 | Restore a shadow copy |
| restore_sel | input | SW | Shadow index, 0 = newest |
| grp_ready | output | 1 | Group accepted this cycle when valid |
| src_a_p | output | GROUP*PW | Physical source A per lane |
| src_b_p | output | GROUP*PW | Physical source B per lane |
| dst_p | output | GROUP*PW | Allocated physical destination per lane |

## Verification
A corrupted map entry shows up on the source ports the first time a later group reads that logical register. Because the bench reads every logical register back after each phase, such an error is caught within a few cycles. A wrong pool bit shows up as a duplicate or skipped allocation on `dst_p`, or as `grp_ready` changing a group too early or too late near exhaustion. A wrong shadow stack shows up as mismatched source reads right after a restore.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int GROUP = 4,
  parameter int LREGS = 32,
  parameter int PREGS = 128,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(LREGS),
  localparam int PW = $clog2(PREGS),
  localparam int SW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grp_valid,
  input  logic [GROUP-1:0]    dst_en,
  input  logic [GROUP*LW-1:0] src_a,
  input  logic [GROUP*LW-1:0] src_b,
  input  logic [GROUP*LW-1:0] dst,
  input  logic                free_en,
  input  logic [PW-1:0]       free_id,
  input  logic                ckpt_push,
  input  logic                restore_en,
  input  logic [SW-1:0]       restore_sel,
  output logic                grp_ready,
  output logic [GROUP*PW-1:0] src_a_p,
  output logic [GROUP*PW-1:0] src_b_p,
  output logic [GROUP*PW-1:0] dst_p
);

  logic [PW-1:0]    map_q [LREGS];
  logic [PW-1:0]    map_n [LREGS];
  logic [PW-1:0]    ck_q  [DEPTH][LREGS];
  logic [PW-1:0]    ck_pop[DEPTH][LREGS];
  logic [CW-1:0]    ck_cnt;
  logic [PREGS-1:0] free_q, free_n;
  logic [PW-1:0]    new_p [GROUP];
  logic [LREGS*PW-1:0] map_flat;
  logic fire, restore_hit;

  assign grp_ready   = !restore_en && ($countones(free_q) >= $countones(dst_en));
  assign fire        = grp_valid && grp_ready;
  assign restore_hit = restore_en && ({1'b0, restore_sel} < ck_cnt);

  always_comb begin
    logic [PREGS-1:0] avail;
    logic found;
    avail = free_q;
    for (int i = 0; i < GROUP; i++) begin
      new_p[i] = '0;
      found = 1'b0;
      if (dst_en[i])
        for (int p = 1; p < PREGS; p++)
          if (!found && avail[p]) begin
            new_p[i] = PW'(p);
            found = 1'b1;
          end
      if (found) avail[new_p[i]] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      logic [PW-1:0] pa, pb;
      pa = map_q[src_a[i*LW +: LW]];
      pb = map_q[src_b[i*LW +: LW]];
      for (int j = 0; j < i; j++) begin
        if (dst_en[j] && dst[j*LW +: LW] == src_a[i*LW +: LW]) pa = new_p[j];
        if (dst_en[j] && dst[j*LW +: LW] == src_b[i*LW +: LW]) pb = new_p[j];
      end
      src_a_p[i*PW +: PW] = pa;
      src_b_p[i*PW +: PW] = pb;
      dst_p[i*PW +: PW]   = new_p[i];
    end
  end

  always_comb begin
    map_n = map_q;
    if (fire)
      for (int i = 0; i < GROUP; i++)
        if (dst_en[i]) map_n[dst[i*LW +: LW]] = new_p[i];
  end

  always_comb begin
    free_n = free_q;
    if (free_en && free_id != '0) free_n[free_id] = 1'b1;
    if (fire)
      for (int i = 0; i < GROUP; i++)
        if (dst_en[i]) free_n[new_p[i]] = 1'b0;
  end

  always_comb begin
    for (int d = 0; d < DEPTH; d++) begin
      ck_pop[d] = ck_q[d];
      for (int s = 0; s < DEPTH; s++)
        if (d + s + 1 < DEPTH && s == int'(restore_sel)) ck_pop[d] = ck_q[d + s + 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LREGS; l++) map_q[l] <= PW'(l);
      for (int d = 0; d < DEPTH; d++)
        for (int l = 0; l < LREGS; l++) ck_q[d][l] <= '0;
      for (int p = 0; p < PREGS; p++) free_q[p] <= (p >= LREGS);
      ck_cnt <= '0;
    end else begin
      free_q <= free_n;
      if (restore_hit) begin
        map_q  <= ck_q[restore_sel];
        ck_q   <= ck_pop;
        ck_cnt <= ck_cnt - CW'(restore_sel) - CW'(1);
      end else begin
        map_q <= map_n;
        if (ckpt_push && !restore_en) begin
          ck_q[0] <= map_n;
          for (int d = 1; d < DEPTH; d++) ck_q[d] <= ck_q[d-1];
          if (ck_cnt != CW'(DEPTH)) ck_cnt <= ck_cnt + CW'(1);
        end
      end
    end
  end

  for (genvar l = 0; l < LREGS; l++) begin : g_flat
    assign map_flat[l*PW +: PW] = map_q[l];
  end

  assert_reg0_never_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !free_q[0]);

  assert_stack_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ck_cnt <= CW'(DEPTH));

  assert_map_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !restore_hit) |=> $stable(map_flat));

  for (genvar i = 0; i < GROUP; i++) begin : g_chk
    assert_from_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dst_en[i]) |-> (free_q[new_p[i]] && new_p[i] != '0));
    assert_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dst_en[i]) |=> !free_q[$past(new_p[i])]);
    for (genvar j = i + 1; j < GROUP; j++) begin : g_pair
      assert_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dst_en[i] && dst_en[j]) |-> new_p[i] != new_p[j]);
    end
  end

endmodule

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int G = 4, L = 32, P = 128, D = 4;

  logic clk = 0, rst_n = 0;
  logic grp_valid = 0, free_en = 0, ckpt_push = 0, restore_en = 0;
  logic [G-1:0] dst_en = '0;
  logic [G*5-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [6:0] free_id = '0;
  logic [1:0] restore_sel = '0;
  logic grp_ready;
  logic [G*7-1:0] src_a_p, src_b_p, dst_p;

  rename_map dut (.*);

  always #4 clk = ~clk;

  typedef struct { bit rdy; bit chk; int a[G]; int b[G]; int d[G]; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  int mmap[L];
  bit mfree[P];
  int mck[D][L];
  int mcn = 0;
  int t_sa[G], t_sb[G], t_dd[G];
  bit [G-1:0] t_en;

  task automatic step(bit v, bit push, bit rest, int sel, bit fen, int fid, string tag);
    item_t it;
    int need = 0, fc = 0;
    bit tf[P];
    @(negedge clk);
    grp_valid = v; ckpt_push = push; restore_en = rest; restore_sel = 2'(sel);
    free_en = fen; free_id = 7'(fid); dst_en = t_en;
    for (int i = 0; i < G; i++) begin
      src_a[i*5 +: 5] = 5'(t_sa[i]); src_b[i*5 +: 5] = 5'(t_sb[i]); dst[i*5 +: 5] = 5'(t_dd[i]);
      need += int'(t_en[i]);
    end
    for (int p = 0; p < P; p++) begin fc += int'(mfree[p]); tf[p] = mfree[p]; end
    it.rdy = !rest && fc >= need;
    it.chk = it.rdy; it.tag = tag;
    for (int i = 0; i < G; i++) begin
      it.d[i] = 0;
      if (t_en[i])
        for (int p = 1; p < P; p++) if (it.d[i] == 0 && tf[p]) begin it.d[i] = p; tf[p] = 0; end
    end
    for (int i = 0; i < G; i++) begin
      it.a[i] = mmap[t_sa[i]]; it.b[i] = mmap[t_sb[i]];
      for (int j = 0; j < i; j++) begin
        if (t_en[j] && t_dd[j] == t_sa[i]) it.a[i] = it.d[j];
        if (t_en[j] && t_dd[j] == t_sb[i]) it.b[i] = it.d[j];
      end
    end
    q.push_back(it);
    if (fen && fid != 0) mfree[fid] = 1;
    if (rest) begin
      if (sel < mcn) begin
        mmap = mck[sel];
        for (int k = 0; k + sel + 1 < D; k++) mck[k] = mck[k + sel + 1];
        mcn -= sel + 1;
      end
    end else begin
      if (v && it.rdy)
        for (int i = 0; i < G; i++) if (t_en[i]) begin mmap[t_dd[i]] = it.d[i]; mfree[it.d[i]] = 0; end
      if (push) begin
        for (int k = D - 1; k > 0; k--) mck[k] = mck[k-1];
        mck[0] = mmap;
        if (mcn < D) mcn++;
      end
    end
  endtask

  task automatic rd(int base, string tag);
    t_en = '0;
    for (int i = 0; i < G; i++) begin t_sa[i] = (base + i) % L; t_sb[i] = (base + i + 16) % L; t_dd[i] = 0; end
    step(1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd_all(string tag);
    for (int k = 0; k < L / G; k++) rd(k * G, tag);
  endtask

  task automatic grp4(int d0, int d1, int d2, int d3, bit [G-1:0] en, string tag);
    t_dd = '{d0, d1, d2, d3}; t_en = en;
    for (int i = 0; i < G; i++) begin t_sa[i] = (d0 + i) % L; t_sb[i] = t_dd[(i + 3) % G]; end
    step(1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic idle();
    t_en = '0;
    step(0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (grp_ready !== it.rdy) begin
          fails++; $display("FAIL %s ready act=%0b exp=%0b", it.tag, grp_ready, it.rdy);
        end
        if (it.chk)
          for (int i = 0; i < G; i++) begin
            checks++;
            if (int'(src_a_p[i*7 +: 7]) != it.a[i] || int'(src_b_p[i*7 +: 7]) != it.b[i] ||
                int'(dst_p[i*7 +: 7]) != it.d[i]) begin
              fails++;
              $display("FAIL %s lane%0d act=%0d/%0d/%0d exp=%0d/%0d/%0d", it.tag, i,
                src_a_p[i*7 +: 7], src_b_p[i*7 +: 7], dst_p[i*7 +: 7], it.a[i], it.b[i], it.d[i]);
            end
          end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    for (int l = 0; l < L; l++) mmap[l] = l;
    for (int p = 0; p < P; p++) mfree[p] = (p >= L);
    for (int k = 0; k < D; k++) for (int l = 0; l < L; l++) mck[k][l] = 0;
    t_en = '0; t_sa = '{0,0,0,0}; t_sb = '{0,0,0,0}; t_dd = '{0,0,0,0};
    repeat (3) @(posedge clk);
    rst_n = 1;
    rd_all("R1 reset map");
    // chained group: r3<-r1,r2 ; r4<-r3,r2 ; r3<-r4,r3 ; r5<-r3,r1
    t_en = 4'b1111; t_dd = '{3, 4, 3, 5};
    t_sa = '{1, 3, 4, 3}; t_sb = '{2, 2, 3, 1};
    step(1, 0, 0, 0, 0, 0, "R2 R3 R4 chained group");
    rd_all("R5 last writer kept");
    grp4(7, 8, 7, 9, 4'b0101, "R2 partial destinations");
    grp4(10, 10, 10, 10, 4'b1111, "R4 R5 same target");
    rd_all("R5 readback");
    // checkpoints
    grp4(11, 12, 13, 14, 4'b1111, "R8 push with rename");
    q[$].tag = "R8 push with rename";
    t_en = 4'b0011; t_dd = '{20, 21, 0, 0};
    step(1, 1, 0, 0, 0, 0, "R8 push captures post-cycle map");
    grp4(20, 21, 22, 23, 4'b1111, "R8 after first push");
    t_en = '0; step(1, 1, 0, 0, 0, 0, "R8 second push");
    grp4(1, 2, 3, 4, 4'b1111, "R8 after second push");
    t_en = 4'b1111; t_dd = '{5, 6, 7, 8};
    step(1, 0, 1, 1, 0, 0, "R9 restore blocks group");
    rd_all("R9 restored to older copy");
    t_en = '0; step(1, 0, 1, 0, 0, 0, "R9 restore on empty stack ignored");
    rd_all("R9 map unchanged after ignored restore");
    step(0, 1, 0, 0, 0, 0, "R10 push");
    grp4(24, 25, 26, 27, 4'b1111, "R10 rename");
    t_en = '0; step(0, 1, 1, 0, 0, 0, "R10 restore with push");
    rd_all("R10 restored");
    t_en = '0; step(0, 0, 1, 0, 0, 0, "R10 push was dropped");
    rd_all("R10 map after ignored restore");
    for (int k = 0; k < D + 1; k++) begin
      grp4(k * 4, k * 4 + 1, k * 4 + 2, k * 4 + 3, 4'b1111, "R8 fill stack");
      t_en = '0; step(0, 1, 0, 0, 0, 0, "R8 fill push");
    end
    t_en = '0; step(0, 0, 1, D - 1, 0, 0, "R8 oldest survivor");
    rd_all("R8 overflow dropped oldest");
    // exhaust pool
    begin
      int fc;
      fc = 0; for (int p = 0; p < P; p++) fc += int'(mfree[p]);
      while (fc >= G) begin
        grp4(fc % L, (fc + 5) % L, (fc + 9) % L, (fc + 13) % L, 4'b1111, "R6 drain pool");
        fc = 0; for (int p = 0; p < P; p++) fc += int'(mfree[p]);
      end
    end
    grp4(1, 2, 3, 4, 4'b1111, "R6 stall when pool short");
    rd_all("R6 map untouched by stall");
    t_en = '0; step(0, 0, 0, 0, 1, 0, "R7 free of reg 0 ignored");
    grp4(1, 2, 3, 4, 4'b1111, "R7 still stalled");
    for (int k = 0; k < G; k++) begin
      t_en = '0; step(0, 0, 0, 0, 1, 40 + k, "R7 return register");
    end
    grp4(1, 2, 3, 4, 4'b1111, "R7 returned registers allocated");
    rd_all("R7 final readback");
    idle();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule